// File: doc/BRIEF.md
# Color Bar and Overlay Source Generator

This block chooses, pixel by pixel, what a video encoder receives as its Y, U, V stream. There are three sources. The first is the incoming image. The second is a solid overlay color picked by three one-bit red, green and blue inputs. The third is an eight-bar test pattern laid out along the line from the current sample count. The bar edges come from one of two per-standard tables: 525-line timing at 13.5 MHz or 625-line timing at 13.5 MHz. Chroma is carried as two's-complement values centred on zero.

The color-bar enable overrides everything. When it is low, the per-pixel overlay enable chooses between the overlay color and the image. A two-bit level control scales both generated sources. It is captured on the pixel whose sample count is zero and is held for the rest of that line. Sync insertion, conversion to DAC codes and the analog stages sit downstream of this block.

Top module: `cbar_src_gen`

## Requirements
- R1: While reset is high and on the first cycles after it, the outputs are black (Y = 16, U = 0, V = 0), and the held level is 100% (code 11).
- R2: Every output is registered with a latency of two clock edges from the inputs. A change at the inputs first shows at the outputs after the second rising edge.
- R3: When `bar_en` is 1, the bar pattern is output for any value of `ovl_en` and of the overlay color bits.
- R4: When `bar_en` is 0 and `ovl_en` is 1, the output is the table color whose index is {`ovl_r`,`ovl_g`,`ovl_b`} (red is bit 2), scaled by the held level.
- R5: When `bar_en` and `ovl_en` are both 0, `img_y`, `img_u` and `img_v` pass to the outputs unchanged.
- R6: At 100%, the table gives these (Y, U, V) values by index: 0 black (16,0,0), 1 blue (41,112,-18), 2 green (145,-74,-94), 3 cyan (170,38,-112), 4 red (81,-38,112), 5 magenta (106,74,94), 6 yellow (210,-112,18), 7 white (235,0,0).
- R7: With level code L (00 = 25%, 01 = 50%, 10 = 75%, 11 = 100%), a generated pixel is Y = 16 + floor((Y100 - 16)(L+1)/4), U = floor(U100(L+1)/4) and V = floor(V100(L+1)/4).
- R8: The level is taken from `lvl_sel` on the pixel whose sample count is 0, and that pixel already uses it. Changes to `lvl_sel` at any other sample count have no effect until the next line start.
- R9: With `std_sel` = 0 (525-line, 858 samples per line), the bar edges are at sample counts 127, 216, 305, 394, 483, 572, 661 and 750.
- R10: With `std_sel` = 1 (625-line, 864 samples per line), the bar edges are at sample counts 142, 230, 318, 406, 494, 582, 670 and 757.
- R11: Bar k covers sample counts from edge k up to edge k+1 minus one. The last bar runs to the end of the line. The order is white, yellow, cyan, green, magenta, red, blue, black. Samples before the first edge give black.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_idx | input | 10 | Sample count within the current line |
| std_sel | input | 1 | Timing table select: 0 = 525-line, 1 = 625-line |
| ovl_r | input | 1 | Overlay red bit |
| ovl_g | input | 1 | Overlay green bit |
| ovl_b | input | 1 | Overlay blue bit |
| ovl_en | input | 1 | Per-pixel overlay enable |
| bar_en | input | 1 | Color-bar enable, highest priority |
| lvl_sel | input | 2 | Generated-source level, captured at sample count 0 |
| img_y | input | 8 | Image luminance |
| img_u | input | 8 | Image U, two's complement |
| img_v | input | 8 | Image V, two's complement |
| out_y | output | 8 | Selected luminance |
| out_u | output | 8 | Selected U, two's complement |
| out_v | output | 8 | Selected V, two's complement |

## Verification
A wrong source choice, table entry or scale factor shows at the outputs two edges after the pixel that caused it. It therefore shows up on the very pixel that exercises it. A wrong edge comparison shows only on the sample counts right next to that edge, so every edge is probed one sample before and exactly at the edge, in both standards and at all four levels. A level register that loads at the wrong time does no harm on the pixel that loads it. It only shows on later pixels of the same line, so those pixels are compared against the level captured at line start while `lvl_sel` holds a different value.

// File: rtl/cbar_pkg.sv
package cbar_pkg;

  localparam int PIX_W  = 8;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    SRC_IMAGE   = 2'd0,
    SRC_OVERLAY = 2'd1,
    SRC_BARS    = 2'd2
  } src_e;

  typedef struct packed {
    logic        [PIX_W-1:0] y;
    logic signed [PIX_W-1:0] u;
    logic signed [PIX_W-1:0] v;
  } yuv_t;

  localparam yuv_t YUV_BLACK = '{y: 8'd16, u: 8'sd0, v: 8'sd0};

  // Full-amplitude studio-range color for an {r,g,b} index
  function automatic yuv_t rgb_to_yuv(input logic [CODE_W-1:0] rgb);
    yuv_t c;
    case (rgb)
      3'd1:    c = '{y: 8'd41,  u:  8'sd112, v: -8'sd18};
      3'd2:    c = '{y: 8'd145, u: -8'sd74,  v: -8'sd94};
      3'd3:    c = '{y: 8'd170, u:  8'sd38,  v: -8'sd112};
      3'd4:    c = '{y: 8'd81,  u: -8'sd38,  v:  8'sd112};
      3'd5:    c = '{y: 8'd106, u:  8'sd74,  v:  8'sd94};
      3'd6:    c = '{y: 8'd210, u: -8'sd112, v:  8'sd18};
      3'd7:    c = '{y: 8'd235, u:  8'sd0,   v:  8'sd0};
      default: c = YUV_BLACK;
    endcase
    return c;
  endfunction

  // Bar position (0 = leftmost) to color index, descending luminance
  function automatic logic [CODE_W-1:0] bar_to_rgb(input logic [CODE_W-1:0] pos);
    logic [CODE_W-1:0] r;
    case (pos)
      3'd0:    r = 3'd7;
      3'd1:    r = 3'd6;
      3'd2:    r = 3'd3;
      3'd3:    r = 3'd2;
      3'd4:    r = 3'd5;
      3'd5:    r = 3'd4;
      3'd6:    r = 3'd1;
      default: r = 3'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cbar_bar_locator.sv
module cbar_bar_locator #(
  parameter int SAMPLE_W = 10,
  parameter int NUM_BARS = 8,
  parameter int IDX_W    = $clog2(NUM_BARS),
  parameter logic [NUM_BARS*SAMPLE_W-1:0] EDGES_A = '0,
  parameter logic [NUM_BARS*SAMPLE_W-1:0] EDGES_B = '0
) (
  input  logic [SAMPLE_W-1:0] sample_idx,
  input  logic                std_sel,
  output logic                in_bars,
  output logic [IDX_W-1:0]    bar_idx
);

  logic [NUM_BARS-1:0] past_edge;

  genvar k;
  generate
    for (k = 0; k < NUM_BARS; k++) begin : g_cmp
      localparam logic [SAMPLE_W-1:0] EDGE_A = EDGES_A[k*SAMPLE_W +: SAMPLE_W];
      localparam logic [SAMPLE_W-1:0] EDGE_B = EDGES_B[k*SAMPLE_W +: SAMPLE_W];
      assign past_edge[k] = (sample_idx >= (std_sel ? EDGE_B : EDGE_A));
    end
  endgenerate

  // Edges ascend, so the highest edge already passed names the bar
  always_comb begin
    bar_idx = '0;
    for (int i = 1; i < NUM_BARS; i++) begin
      if (past_edge[i]) bar_idx = IDX_W'(i);
    end
  end

  assign in_bars = past_edge[0];

endmodule

// File: rtl/cbar_level_ctl.sv
module cbar_level_ctl #(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic [LVL_W-1:0] lvl_in,
  output logic [LVL_W-1:0] lvl_eff
);

  logic [LVL_W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst)             lvl_q <= '1;
    else if (line_start) lvl_q <= lvl_in;
  end

  // The line-start pixel already uses the newly presented level
  assign lvl_eff = line_start ? lvl_in : lvl_q;

endmodule

// File: rtl/cbar_color_scaler.sv
module cbar_color_scaler
  import cbar_pkg::*;
#(
  parameter int LVL_W = 2
) (
  input  logic [CODE_W-1:0] rgb,
  input  logic [LVL_W-1:0]  lvl,
  output yuv_t              color
);

  localparam int PROD_W = PIX_W + LVL_W + 1;

  yuv_t                     base;
  logic        [LVL_W:0]    mult;
  logic        [PROD_W-1:0] y_prod;
  logic signed [PROD_W-1:0] u_prod;
  logic signed [PROD_W-1:0] v_prod;

  always_comb begin
    base   = rgb_to_yuv(rgb);
    mult   = {1'b0, lvl} + 1'b1;
    y_prod = PROD_W'(base.y - 8'd16) * PROD_W'(mult);
    u_prod = PROD_W'(base.u) * $signed(PROD_W'(mult));
    v_prod = PROD_W'(base.v) * $signed(PROD_W'(mult));
    color.y = PIX_W'(8'd16 + PIX_W'(y_prod >> LVL_W));
    color.u = PIX_W'(u_prod >>> LVL_W);
    color.v = PIX_W'(v_prod >>> LVL_W);
  end

endmodule

// File: rtl/cbar_src_gen.sv
module cbar_src_gen
  import cbar_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int NUM_BARS = 8,
  parameter int LVL_W    = 2,
  parameter logic [NUM_BARS*SAMPLE_W-1:0] EDGES_A =
    {10'd750, 10'd661, 10'd572, 10'd483, 10'd394, 10'd305, 10'd216, 10'd127},
  parameter logic [NUM_BARS*SAMPLE_W-1:0] EDGES_B =
    {10'd757, 10'd670, 10'd582, 10'd494, 10'd406, 10'd318, 10'd230, 10'd142}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SAMPLE_W-1:0]     sample_idx,
  input  logic                    std_sel,
  input  logic                    ovl_r,
  input  logic                    ovl_g,
  input  logic                    ovl_b,
  input  logic                    ovl_en,
  input  logic                    bar_en,
  input  logic [LVL_W-1:0]        lvl_sel,
  input  logic [PIX_W-1:0]        img_y,
  input  logic signed [PIX_W-1:0] img_u,
  input  logic signed [PIX_W-1:0] img_v,
  output logic [PIX_W-1:0]        out_y,
  output logic signed [PIX_W-1:0] out_u,
  output logic signed [PIX_W-1:0] out_v
);

  localparam int IDX_W = $clog2(NUM_BARS);

  logic              line_start;
  logic [LVL_W-1:0]  lvl_eff;
  logic              in_bars;
  logic [IDX_W-1:0]  bar_idx;
  src_e              src_d;
  logic [CODE_W-1:0] code_d;

  // Stage 1 state
  src_e              src_q;
  logic [CODE_W-1:0] code_q;
  logic [LVL_W-1:0]  lvl_q;
  yuv_t              img_q;

  yuv_t              gen_color;

  assign line_start = (sample_idx == '0);

  cbar_level_ctl #(.LVL_W(LVL_W)) u_level (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .lvl_in     (lvl_sel),
    .lvl_eff    (lvl_eff)
  );

  cbar_bar_locator #(
    .SAMPLE_W (SAMPLE_W),
    .NUM_BARS (NUM_BARS),
    .IDX_W    (IDX_W),
    .EDGES_A  (EDGES_A),
    .EDGES_B  (EDGES_B)
  ) u_locate (
    .sample_idx (sample_idx),
    .std_sel    (std_sel),
    .in_bars    (in_bars),
    .bar_idx    (bar_idx)
  );

  // Source priority: bars, then overlay, then image
  always_comb begin
    if (bar_en) begin
      src_d  = SRC_BARS;
      code_d = in_bars ? bar_to_rgb(CODE_W'(bar_idx)) : 3'd0;
    end else if (ovl_en) begin
      src_d  = SRC_OVERLAY;
      code_d = {ovl_r, ovl_g, ovl_b};
    end else begin
      src_d  = SRC_IMAGE;
      code_d = 3'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_OVERLAY;
      code_q <= '0;
      lvl_q  <= '1;
      img_q  <= YUV_BLACK;
    end else begin
      src_q  <= src_d;
      code_q <= code_d;
      lvl_q  <= lvl_eff;
      img_q  <= '{y: img_y, u: img_u, v: img_v};
    end
  end

  cbar_color_scaler #(.LVL_W(LVL_W)) u_scale (
    .rgb   (code_q),
    .lvl   (lvl_q),
    .color (gen_color)
  );

  // Stage 2: registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      out_y <= YUV_BLACK.y;
      out_u <= YUV_BLACK.u;
      out_v <= YUV_BLACK.v;
    end else if (src_q == SRC_IMAGE) begin
      out_y <= img_q.y;
      out_u <= img_q.u;
      out_v <= img_q.v;
    end else begin
      out_y <= gen_color.y;
      out_u <= gen_color.u;
      out_v <= gen_color.v;
    end
  end

endmodule

// File: rtl/cbar_src_gen_chk.sv
module cbar_src_gen_chk #(
  parameter int SAMPLE_W = 10,
  parameter int NUM_BARS = 8,
  parameter int LVL_W    = 2,
  parameter logic [NUM_BARS*SAMPLE_W-1:0] EDGES_A = '0,
  parameter logic [NUM_BARS*SAMPLE_W-1:0] EDGES_B = '0
) (
  input logic                clk,
  input logic                rst,
  input logic [SAMPLE_W-1:0] sample_idx,
  input logic                std_sel,
  input logic                ovl_r,
  input logic                ovl_g,
  input logic                ovl_b,
  input logic                ovl_en,
  input logic                bar_en,
  input logic [LVL_W-1:0]    lvl_sel,
  input logic [7:0]          img_y,
  input logic signed [7:0]   img_u,
  input logic signed [7:0]   img_v,
  input logic [7:0]          out_y,
  input logic signed [7:0]   out_u,
  input logic signed [7:0]   out_v
);

  localparam logic [SAMPLE_W-1:0] FIRST_A = EDGES_A[SAMPLE_W-1:0];
  localparam logic [SAMPLE_W-1:0] FIRST_B = EDGES_B[SAMPLE_W-1:0];

  logic [1:0] warm;
  logic       lead_black;

  always_ff @(posedge clk) begin
    if (rst)              warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assign lead_black = std_sel ? (sample_idx < FIRST_B) : (sample_idx < FIRST_A);

  // R1: outputs are black on the first edge after reset is released
  assert_reset_black_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_y == 8'd16 && out_u == 8'sd0 && out_v == 8'sd0));

  // R5: image passes through untouched two edges later
  assert_image_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (warm[1] && $past(!bar_en && !ovl_en, 2)) |->
      (out_y == $past(img_y, 2) && out_u == $past(img_u, 2) && out_v == $past(img_v, 2)));

  // R3: bars override overlay; the lead-in region before the first edge is black
  assert_bar_priority_R3: assert property (@(posedge clk) disable iff (rst)
    (warm[1] && $past(bar_en && lead_black, 2)) |->
      (out_y == 8'd16 && out_u == 8'sd0 && out_v == 8'sd0));

  // R4: overlay index zero is black at every level
  assert_ovl_black_R4: assert property (@(posedge clk) disable iff (rst)
    (warm[1] && $past(!bar_en && ovl_en && !ovl_r && !ovl_g && !ovl_b, 2)) |->
      (out_y == 8'd16 && out_u == 8'sd0 && out_v == 8'sd0));

  // R7: generated pixels stay within studio range
  assert_gen_range_R7: assert property (@(posedge clk) disable iff (rst)
    (warm[1] && $past(bar_en || ovl_en, 2)) |->
      (out_y >= 8'd16 && out_y <= 8'd235 &&
       out_u >= -8'sd112 && out_u <= 8'sd112 &&
       out_v >= -8'sd112 && out_v <= 8'sd112));

endmodule

bind cbar_src_gen cbar_src_gen_chk #(
  .SAMPLE_W (SAMPLE_W),
  .NUM_BARS (NUM_BARS),
  .LVL_W    (LVL_W),
  .EDGES_A  (EDGES_A),
  .EDGES_B  (EDGES_B)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sample_idx (sample_idx),
  .std_sel    (std_sel),
  .ovl_r      (ovl_r),
  .ovl_g      (ovl_g),
  .ovl_b      (ovl_b),
  .ovl_en     (ovl_en),
  .bar_en     (bar_en),
  .lvl_sel    (lvl_sel),
  .img_y      (img_y),
  .img_u      (img_u),
  .img_v      (img_v),
  .out_y      (out_y),
  .out_u      (out_u),
  .out_v      (out_v)
);

// File: tb/tb_cbar_src_gen.sv
module tb_cbar_src_gen;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [9:0]        sample_idx = 10'd100;
  logic              std_sel = 1'b0;
  logic              ovl_r = 1'b0, ovl_g = 1'b0, ovl_b = 1'b0;
  logic              ovl_en = 1'b0, bar_en = 1'b0;
  logic [1:0]        lvl_sel = 2'b00;
  logic [7:0]        img_y = 8'd0;
  logic signed [7:0] img_u = 8'sd0, img_v = 8'sd0;
  logic [7:0]        out_y;
  logic signed [7:0] out_u, out_v;

  int   checks = 0;
  int   failures = 0;
  bit   done = 0;
  logic [1:0] cur_lvl = 2'b11;

  always #4 clk = ~clk;

  cbar_src_gen dut (
    .clk (clk), .rst (rst), .sample_idx (sample_idx), .std_sel (std_sel),
    .ovl_r (ovl_r), .ovl_g (ovl_g), .ovl_b (ovl_b), .ovl_en (ovl_en),
    .bar_en (bar_en), .lvl_sel (lvl_sel), .img_y (img_y), .img_u (img_u),
    .img_v (img_v), .out_y (out_y), .out_u (out_u), .out_v (out_v)
  );

  typedef struct packed {
    logic              bar;
    logic              ovl;
    logic [2:0]        rgb;
    logic              std;
    logic [9:0]        smp;
    logic [7:0]        iy;
    logic signed [7:0] iu;
    logic signed [7:0] iv;
  } vec_t;

  // bar, ovl, rgb, std, sample, image y/u/v
  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b0, 3'd5, 1'b0, 10'd300, 8'd200, -8'sd7,  8'sd90},   // R5
    '{1'b0, 1'b0, 3'd0, 1'b1, 10'd12,  8'd3,   8'sd127, -8'sd128}, // R5
    '{1'b0, 1'b1, 3'd7, 1'b0, 10'd400, 8'd50,  8'sd1,   8'sd1},    // R4
    '{1'b0, 1'b1, 3'd6, 1'b1, 10'd20,  8'd50,  8'sd1,   8'sd1},    // R4
    '{1'b0, 1'b1, 3'd3, 1'b0, 10'd800, 8'd50,  8'sd1,   8'sd1},    // R4
    '{1'b0, 1'b1, 3'd2, 1'b0, 10'd5,   8'd50,  8'sd1,   8'sd1},    // R4
    '{1'b0, 1'b1, 3'd5, 1'b1, 10'd600, 8'd50,  8'sd1,   8'sd1},    // R4
    '{1'b0, 1'b1, 3'd4, 1'b0, 10'd130, 8'd50,  8'sd1,   8'sd1},    // R4
    '{1'b0, 1'b1, 3'd1, 1'b0, 10'd700, 8'd50,  8'sd1,   8'sd1},    // R4
    '{1'b1, 1'b1, 3'd1, 1'b0, 10'd200, 8'd99,  8'sd9,   8'sd9},    // R3
    '{1'b1, 1'b0, 3'd0, 1'b1, 10'd240, 8'd99,  8'sd9,   8'sd9},    // R3
    '{1'b1, 1'b1, 3'd0, 1'b0, 10'd50,  8'd99,  8'sd9,   8'sd9}     // R3 lead-in
  };

  int e525 [8] = '{127, 216, 305, 394, 483, 572, 661, 750};
  int e625 [8] = '{142, 230, 318, 406, 494, 582, 670, 757};
  int bar_rgb [8] = '{7, 6, 3, 2, 5, 4, 1, 0};
  int ref_y  [8] = '{16, 41, 145, 170, 81, 106, 210, 235};
  int ref_cb [8] = '{128, 240, 54, 166, 90, 202, 16, 128};
  int ref_cr [8] = '{128, 110, 34, 16, 240, 222, 146, 128};

  function automatic int floor_q(int p);
    return (p >= 0) ? p / 4 : -((-p + 3) / 4);
  endfunction

  function automatic void model(input vec_t v, input logic [1:0] lvl,
                                output int ey, output int eu, output int ev);
    int idx, m;
    m = lvl + 1;
    if (!v.bar && !v.ovl) begin
      ey = v.iy; eu = v.iu; ev = v.iv;
      return;
    end
    if (v.bar) begin
      idx = 0;
      for (int k = 0; k < 8; k++) begin
        if (v.smp >= (v.std ? e625[k] : e525[k])) idx = bar_rgb[k];
      end
    end else begin
      idx = v.rgb;
    end
    ey = 16 + ((ref_y[idx] - 16) * m) / 4;
    eu = floor_q((ref_cb[idx] - 128) * m);
    ev = floor_q((ref_cr[idx] - 128) * m);
  endfunction

  task automatic check_out(input string req, input int ey, input int eu, input int ev);
    checks++;
    if (int'(out_y) != ey || int'(out_u) != eu || int'(out_v) != ev) begin
      failures++;
      $display("FAIL %s: got y=%0d u=%0d v=%0d expected y=%0d u=%0d v=%0d",
               req, out_y, out_u, out_v, ey, eu, ev);
    end
  endtask

  task automatic drive(input vec_t v, input logic [1:0] lvl_in);
    bar_en = v.bar; ovl_en = v.ovl;
    {ovl_r, ovl_g, ovl_b} = v.rgb;
    std_sel = v.std; sample_idx = v.smp;
    img_y = v.iy; img_u = v.iu; img_v = v.iv;
    lvl_sel = lvl_in;
  endtask

  // Present one pixel, hold two edges, compare against the model
  task automatic apply(input vec_t v, input string req);
    int ey, eu, ev;
    @(negedge clk);
    drive(v, ~cur_lvl);  // off-line-start level changes must be ignored
    @(posedge clk);
    @(posedge clk);
    #2;
    model(v, cur_lvl, ey, eu, ev);
    check_out(req, ey, eu, ev);
  endtask

  task automatic start_line(input logic std, input logic [1:0] lvl);
    vec_t v;
    v = '{1'b0, 1'b0, 3'd0, std, 10'd0, 8'd16, 8'sd0, 8'sd0};
    @(negedge clk);
    drive(v, lvl);
    @(posedge clk);
    cur_lvl = lvl;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    vec_t v;
    int ey, eu, ev;

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check_out("R1 reset black", 16, 0, 0);
    @(negedge clk);
    rst = 1'b0;

    // R1/R8: held level is 100% before any line start
    v = '{1'b1, 1'b0, 3'd0, 1'b0, 10'd200, 8'd0, 8'sd0, 8'sd0};
    apply(v, "R8 default level 100%");

    // R8: level captured at sample 0, later lvl_sel ignored
    start_line(1'b0, 2'b01);
    apply(v, "R8 level held mid-line");
    checks++;
    if (out_y != 8'd125) begin
      failures++;
      $display("FAIL R7 50%% white: got y=%0d expected y=125", out_y);
    end

    // R2: two-edge latency
    start_line(1'b0, 2'b11);
    v = '{1'b0, 1'b0, 3'd0, 1'b0, 10'd300, 8'd50, 8'sd5, -8'sd5};
    apply(v, "R2 latency settle");
    @(negedge clk);
    img_y = 8'd60; img_u = 8'sd6; img_v = -8'sd6;
    @(posedge clk); #2;
    check_out("R2 one edge holds old", 50, 5, -5);
    @(posedge clk); #2;
    check_out("R2 two edges show new", 60, 6, -6);

    // Vector table: R3 R4 R5, at two levels
    for (int l = 3; l >= 1; l -= 2) begin
      start_line(1'b0, 2'(l));
      foreach (VECS[i]) apply(VECS[i], "R3/R4/R5 vector");
    end

    // R6 R7: every overlay color at every level
    for (int l = 0; l < 4; l++) begin
      start_line(1'b1, 2'(l));
      for (int c = 0; c < 8; c++) begin
        v = '{1'b0, 1'b1, 3'(c), 1'b1, 10'd400, 8'd0, 8'sd0, 8'sd0};
        apply(v, "R6/R7 overlay color");
      end
    end

    // R9 R10 R11: both sides of every edge, both timings, all levels
    for (int s = 0; s < 2; s++) begin
      for (int l = 0; l < 4; l++) begin
        start_line(1'(s), 2'(l));
        for (int k = 0; k < 8; k++) begin
          for (int side = 0; side < 2; side++) begin
            int e;
            e = (s == 1) ? e625[k] : e525[k];
            v = '{1'b1, 1'(k), 3'(7 - k), 1'(s), 10'(e - 1 + side), 8'd0, 8'sd0, 8'sd0};
            apply(v, (s == 1) ? "R10 R11 edge 625" : "R9 R11 edge 525");
          end
        end
        v = '{1'b1, 1'b1, 3'd7, 1'(s), (s == 1) ? 10'd863 : 10'd857, 8'd0, 8'sd0, 8'sd0};
        apply(v, "R11 last sample black");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule